// File: doc/BRIEF.md
# Stop-Mode Wake and Oscillator Stabilization Controller

This block sets the power mode of a small microcontroller core. It takes a stop request, an idle request, a set of external interrupt lines, the active-low reset pin and a supply-low flag. From these it drives the oscillator enable, the CPU clock gate, a CPU release signal, a back-up indication, and a periodic instruction-clock enable for the core.

Stop turns the oscillator off. Only three events end it: an interrupt, the reset pin, or the supply-low flag. After an interrupt the core waits a stabilization interval chosen by a 2-bit select. After a reset or a supply-low exit it waits a fixed, longer interval. Idle gates only the CPU clock, and an interrupt resumes execution at once. The core is held in back-up while the accepted reset pin is low or the supply-low flag is set.

All counts are in cycles of `clk`, the oscillator clock seen by the controller. The reset pin and the interrupt lines pass through pulse-width filters before they are used.

Top module: `pm_stop_wake_ctrl`

## Requirements
- R1: While `por_n` is low, and after it rises while `reset_pin_n` is still low, `backup`=1 and `osc_en`, `cpu_clk_en`, `cpu_run` and `instr_en` are all 0.
- R2: A level on `reset_pin_n` is accepted only after it holds for RST_FILT (8) consecutive cycles. A low pulse of RST_FILT-1 cycles has no effect. A low level of RST_FILT cycles puts the block in back-up on the following cycle.
- R3: Leaving back-up because the accepted pin is high and `lvd_low` is 0 starts a wait of 2^RST_WAIT_LOG2 cycles. `cpu_clk_en` rises RST_FILT+1+2^RST_WAIT_LOG2 cycles after the pin goes high.
- R4: `lvd_low`=1 forces back-up on the next cycle from any state, with no filtering. When it clears, the fixed wait follows, so `cpu_clk_en` rises 1+2^RST_WAIT_LOG2 cycles later.
- R5: `stop_req` in run mode enters stop on the next cycle: `osc_en`=0 and `cpu_clk_en`=0. If `stop_req` and `idle_req` are both high, stop wins.
- R6: An interrupt line is accepted only after it holds high for INT_FILT (2) cycles. A 1-cycle pulse does not wake the block from stop.
- R7: An accepted interrupt in stop starts a wait of 2^W cycles, where `int_wait_sel` 0,1,2,3 selects W = WAIT_LOG2_0..3 (defaults 8, 11, 13, 16). `cpu_clk_en` rises INT_FILT+1+2^W cycles after the line goes high. The select is captured when the wait starts, so later changes do not alter it.
- R8: `idle_req` in run mode enters idle: `cpu_clk_en`=0, `osc_en`=1, `cpu_run`=1. An accepted interrupt returns to run on the next cycle with no wait, INT_FILT+1 cycles after the line rises.
- R9: If the accepted reset pin falls in the same cycle as an accepted interrupt in stop, the block enters back-up, and the later release uses the fixed wait of R3.
- R10: In run mode, `instr_en` pulses once every 6·n cycles, where `clk_div_sel` 0,1,2,3 gives n = 1, 2, 8, 16. It is 0 outside run mode.
- R11: `cpu_run` stays 0 for the whole stabilization wait and rises on the cycle after the wait counter reaches its terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock seen by the controller |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| reset_pin_n | input | 1 | External reset / back-up pin, active low, filtered |
| lvd_low | input | 1 | Supply below threshold flag |
| stop_req | input | 1 | Stop request from the core |
| idle_req | input | 1 | Idle request from the core |
| ext_int | input | NUM_INT | External interrupt lines, active high, filtered |
| int_wait_sel | input | 2 | Wait length select for interrupt wakes |
| clk_div_sel | input | 2 | Instruction clock divide select |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| cpu_run | output | 1 | CPU released (run or idle) |
| backup | output | 1 | Back-up mode indication |
| instr_en | output | 1 | Instruction clock enable pulse |

## Verification
Two things can land in the same cycle in stop: the reset filter accepting a low pin and the interrupt filter accepting a wake. The bench lines them up by driving the reset pin low and then raising an interrupt line six cycles later. Both filters then flip on the same edge. The result is judged in two ways: `backup` must be high on the next cycle, and the release must take exactly the fixed reset wait rather than the shorter interrupt wait.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;

   typedef enum logic [2:0] {
      PM_BACKUP = 3'd0,
      PM_WAIT   = 3'd1,
      PM_RUN    = 3'd2,
      PM_IDLE   = 3'd3,
      PM_STOP   = 3'd4
   } pm_state_e;

   // Divide multiplier n for the instruction clock select.
   function automatic int unsigned div_mult(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 2;
         2'd2:    return 8;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/pm_glitch_filter.sv
`timescale 1ns/1ps
module pm_glitch_filter #(
   parameter int unsigned CYCLES = 2,
   parameter bit          INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (CYCLES < 1) begin : g_bad
         $error("pm_glitch_filter: CYCLES must be at least 1");
      end

      if (CYCLES == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= INIT;
            else        dout <= din;
         end
      end else begin : g_count
         localparam int unsigned CW = $clog2(CYCLES);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dout  <= INIT;
               run_q <= '0;
            end else if (din == dout) begin
               run_q <= '0;
            end else if (run_q == CW'(CYCLES - 1)) begin
               dout  <= din;
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   // Output may only move after the input disagreed with it.
   assert_filter_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (din == dout) |=> $stable(dout));

endmodule

// File: rtl/pm_stab_timer.sv
`timescale 1ns/1ps
module pm_stab_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [4:0] lim_log2,
   output logic       term
);

   generate
      if (CNT_W < 1 || CNT_W > 30) begin : g_bad
         $error("pm_stab_timer: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   last_v;

   always_comb begin
      last_v = ((CNT_W+1)'(1) << lim_log2) - (CNT_W+1)'(1);
      term   = en && (cnt_q == last_v[CNT_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (!en) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
   end

   assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt_q <= last_v[CNT_W-1:0]));

endmodule

// File: rtl/pm_instr_div.sv
`timescale 1ns/1ps
module pm_instr_div
   import pm_pkg::*;
#(
   parameter int unsigned BASE = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);

   localparam int unsigned DW = $clog2(BASE * 16);

   generate
      if (BASE < 2) begin : g_bad
         $error("pm_instr_div: BASE must be at least 2");
      end
   endgenerate

   logic [DW-1:0] cnt_q;
   logic [DW-1:0] top_v;

   always_comb begin
      top_v = DW'(BASE * div_mult(sel) - 1);
      tick  = run && (cnt_q >= top_v);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run)           cnt_q <= '0;
      else if (cnt_q >= top_v) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/pm_stop_wake_ctrl.sv
`timescale 1ns/1ps
module pm_stop_wake_ctrl
   import pm_pkg::*;
#(
   parameter int unsigned NUM_INT       = 12,
   parameter int unsigned INT_FILT      = 2,
   parameter int unsigned RST_FILT      = 8,
   parameter int unsigned RST_WAIT_LOG2 = 16,
   parameter int unsigned WAIT_LOG2_0   = 8,
   parameter int unsigned WAIT_LOG2_1   = 11,
   parameter int unsigned WAIT_LOG2_2   = 13,
   parameter int unsigned WAIT_LOG2_3   = 16,
   parameter int unsigned DIV_BASE      = 6
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               reset_pin_n,
   input  logic               lvd_low,
   input  logic               stop_req,
   input  logic               idle_req,
   input  logic [NUM_INT-1:0] ext_int,
   input  logic [1:0]         int_wait_sel,
   input  logic [1:0]         clk_div_sel,
   output logic               osc_en,
   output logic               cpu_clk_en,
   output logic               cpu_run,
   output logic               backup,
   output logic               instr_en
);

   localparam int unsigned MAX_A    = (WAIT_LOG2_0 > WAIT_LOG2_1) ? WAIT_LOG2_0 : WAIT_LOG2_1;
   localparam int unsigned MAX_B    = (WAIT_LOG2_2 > WAIT_LOG2_3) ? WAIT_LOG2_2 : WAIT_LOG2_3;
   localparam int unsigned MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned MAX_LOG2 = (MAX_C > RST_WAIT_LOG2) ? MAX_C : RST_WAIT_LOG2;

   generate
      if (NUM_INT < 1) begin : g_bad_int
         $error("pm_stop_wake_ctrl: NUM_INT must be at least 1");
      end
      if (MAX_LOG2 > 24 || WAIT_LOG2_0 < 1 || RST_WAIT_LOG2 < 1) begin : g_bad_wait
         $error("pm_stop_wake_ctrl: wait exponents out of range");
      end
   endgenerate

   // ---------------- input filters ----------------
   logic               rst_f;
   logic [NUM_INT-1:0] int_f;
   logic               int_any;

   pm_glitch_filter #(.CYCLES(RST_FILT), .INIT(1'b0)) u_rst_filt (
      .clk  (clk),
      .rst_n(por_n),
      .din  (reset_pin_n),
      .dout (rst_f)
   );

   generate
      for (genvar i = 0; i < NUM_INT; i++) begin : g_int_filt
         pm_glitch_filter #(.CYCLES(INT_FILT), .INIT(1'b0)) u_filt (
            .clk  (clk),
            .rst_n(por_n),
            .din  (ext_int[i]),
            .dout (int_f[i])
         );
      end
   endgenerate

   assign int_any = |int_f;

   // ---------------- mode state machine ----------------
   pm_state_e  state_q, state_d;
   logic [4:0] wlog_q, wlog_d, int_log2;
   logic       wait_term;

   always_comb begin
      case (int_wait_sel)
         2'd0:    int_log2 = 5'(WAIT_LOG2_0);
         2'd1:    int_log2 = 5'(WAIT_LOG2_1);
         2'd2:    int_log2 = 5'(WAIT_LOG2_2);
         default: int_log2 = 5'(WAIT_LOG2_3);
      endcase
   end

   always_comb begin
      state_d = state_q;
      wlog_d  = 5'(RST_WAIT_LOG2);
      if (!rst_f || lvd_low) begin
         state_d = PM_BACKUP;
      end else begin
         case (state_q)
            PM_BACKUP: state_d = PM_WAIT;
            PM_WAIT:   if (wait_term) state_d = PM_RUN;
            PM_RUN: begin
               if (stop_req)      state_d = PM_STOP;
               else if (idle_req) state_d = PM_IDLE;
            end
            PM_IDLE:   if (int_any) state_d = PM_RUN;
            PM_STOP: begin
               if (int_any) begin
                  state_d = PM_WAIT;
                  wlog_d  = int_log2;
               end
            end
            default:   state_d = PM_BACKUP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= PM_BACKUP;
         wlog_q  <= 5'(RST_WAIT_LOG2);
      end else begin
         state_q <= state_d;
         if (state_d == PM_WAIT && state_q != PM_WAIT) wlog_q <= wlog_d;
      end
   end

   pm_stab_timer #(.CNT_W(MAX_LOG2)) u_timer (
      .clk     (clk),
      .rst_n   (por_n),
      .en      (state_q == PM_WAIT),
      .lim_log2(wlog_q),
      .term    (wait_term)
   );

   // ---------------- outputs ----------------
   assign backup     = (state_q == PM_BACKUP);
   assign osc_en     = (state_q == PM_WAIT) || (state_q == PM_RUN) || (state_q == PM_IDLE);
   assign cpu_clk_en = (state_q == PM_RUN);
   assign cpu_run    = (state_q == PM_RUN) || (state_q == PM_IDLE);

   pm_instr_div #(.BASE(DIV_BASE)) u_div (
      .clk  (clk),
      .rst_n(por_n),
      .run  (cpu_clk_en),
      .sel  (clk_div_sel),
      .tick (instr_en)
   );

   // ---------------- assertions ----------------
   assert_lvd_backup_R4: assert property (@(posedge clk) disable iff (!por_n)
      lvd_low |=> backup);

   assert_stop_osc_off_R5: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_RUN && stop_req && rst_f && !lvd_low) |=> (!osc_en && !cpu_clk_en));

   assert_idle_no_wait_R8: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == PM_IDLE && int_any && rst_f && !lvd_low) |=> cpu_clk_en);

   assert_reset_wins_R9: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_f && int_any) |=> backup);

   assert_run_after_wait_R11: assert property (@(posedge clk) disable iff (!por_n)
      $rose(cpu_run) |-> ($past(state_q) == PM_WAIT && $past(wait_term)));

   assert_instr_in_run_R10: assert property (@(posedge clk) disable iff (!por_n)
      instr_en |-> osc_en);

endmodule

// File: tb/tb_pm_stop_wake_ctrl.sv
`timescale 1ns/1ps
module tb_pm_stop_wake_ctrl;

   localparam int NI   = 4;
   localparam int RF   = 8;
   localparam int IF_C = 2;
   localparam int RW   = 7;
   localparam int WL [4] = '{2, 3, 4, 5};
   localparam int RST_WAKE = RF + 1 + (1 << RW);

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          por_n, reset_pin_n, lvd_low, stop_req, idle_req;
   logic [NI-1:0] ext_int;
   logic [1:0]    int_wait_sel, clk_div_sel;
   logic          osc_en, cpu_clk_en, cpu_run, backup, instr_en;

   pm_stop_wake_ctrl #(
      .NUM_INT(NI), .INT_FILT(IF_C), .RST_FILT(RF), .RST_WAIT_LOG2(RW),
      .WAIT_LOG2_0(WL[0]), .WAIT_LOG2_1(WL[1]), .WAIT_LOG2_2(WL[2]), .WAIT_LOG2_3(WL[3]),
      .DIV_BASE(6)
   ) dut (
      .clk(clk), .por_n(por_n), .reset_pin_n(reset_pin_n), .lvd_low(lvd_low),
      .stop_req(stop_req), .idle_req(idle_req), .ext_int(ext_int),
      .int_wait_sel(int_wait_sel), .clk_div_sel(clk_div_sel),
      .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .cpu_run(cpu_run),
      .backup(backup), .instr_en(instr_en)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Counts edges from the current negedge until cpu_clk_en is seen high.
   task automatic wake_count(input string req, input int exp, input bit held, input bit swap_sel);
      int n = 0;
      bit early = 1'b0;
      do begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (swap_sel && n == 5) int_wait_sel = int_wait_sel + 2'd1;
         if (held && cpu_run && !cpu_clk_en) early = 1'b1;
      end while (!cpu_clk_en && n < 4000);
      chk(req, n, exp);
      if (held) chk("R11 cpu_run low through wait", int'(early), 0);
   endtask

   task automatic pulse_stop();
      @(negedge clk) stop_req = 1'b1;
      @(negedge clk) stop_req = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      por_n = 1'b0; reset_pin_n = 1'b0; lvd_low = 1'b0;
      stop_req = 1'b0; idle_req = 1'b0; ext_int = '0;
      int_wait_sel = 2'd0; clk_div_sel = 2'd0;
      repeat (3) @(negedge clk);
      chk("R1 backup in por", int'(backup), 1);
      chk("R1 osc_en in por", int'(osc_en), 0);
      chk("R1 cpu_clk_en in por", int'(cpu_clk_en), 0);
      chk("R1 instr_en in por", int'(instr_en), 0);
      por_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 backup with pin low", int'(backup), 1);
      chk("R1 cpu_run with pin low", int'(cpu_run), 0);

      // R3: release from back-up
      reset_pin_n = 1'b1;
      wake_count("R3 reset release wait", RST_WAKE, 1'b1, 1'b0);
      chk("R3 cpu_run after wait", int'(cpu_run), 1);

      // R10: instruction clock divide sweep
      for (int s = 0; s < 4; s++) begin
         int k = 0;
         int g = 0;
         int nmul;
         nmul = (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 8 : 16;
         clk_div_sel = 2'(s);
         while (!instr_en && g < 300) begin @(negedge clk); g++; end
         do begin @(negedge clk); k++; end while (!instr_en && k < 300);
         chk("R10 instr_en period", k, 6 * nmul);
      end

      // R2: short reset low pulse ignored
      @(negedge clk) reset_pin_n = 1'b0;
      repeat (RF - 1) @(posedge clk);
      @(negedge clk) reset_pin_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2 short pin pulse no backup", int'(backup), 0);
      chk("R2 short pin pulse still running", int'(cpu_clk_en), 1);

      // R2: full-width reset accepted
      @(negedge clk) reset_pin_n = 1'b0;
      repeat (RF) @(posedge clk);
      @(negedge clk);
      chk("R2 no backup at filter edge", int'(backup), 0);
      @(posedge clk);
      @(negedge clk);
      chk("R2 backup after filter", int'(backup), 1);
      reset_pin_n = 1'b1;
      wake_count("R3 wait after pin reset", RST_WAKE, 1'b1, 1'b0);

      // R5: stop wins over idle
      @(negedge clk) begin stop_req = 1'b1; idle_req = 1'b1; end
      @(negedge clk) begin stop_req = 1'b0; idle_req = 1'b0; end
      chk("R5 osc off in stop", int'(osc_en), 0);
      chk("R5 cpu clock off in stop", int'(cpu_clk_en), 0);
      chk("R10 instr_en off in stop", int'(instr_en), 0);

      // R6: one-cycle interrupt glitch ignored
      @(negedge clk) ext_int[1] = 1'b1;
      @(negedge clk) ext_int[1] = 1'b0;
      repeat (6) @(negedge clk);
      chk("R6 glitch does not wake", int'(osc_en), 0);

      // R7: interrupt wake sweep over wait select
      for (int s = 0; s < 4; s++) begin
         if (s > 0) pulse_stop();
         int_wait_sel = 2'(s);
         ext_int[s] = 1'b1;
         wake_count("R7 interrupt wake wait", IF_C + 1 + (1 << WL[s]), 1'b1, s == 2);
         ext_int = '0;
         repeat (4) @(negedge clk);
      end

      // R8: idle and immediate resume
      @(negedge clk) idle_req = 1'b1;
      @(negedge clk) idle_req = 1'b0;
      chk("R8 idle keeps oscillator", int'(osc_en), 1);
      chk("R8 idle gates cpu clock", int'(cpu_clk_en), 0);
      chk("R8 idle keeps cpu_run", int'(cpu_run), 1);
      repeat (5) @(negedge clk);
      ext_int[0] = 1'b1;
      wake_count("R8 idle resume delay", IF_C + 1, 1'b0, 1'b0);
      ext_int = '0;
      repeat (4) @(negedge clk);

      // R4: supply-low from run and from stop
      @(negedge clk) lvd_low = 1'b1;
      @(negedge clk);
      chk("R4 backup on lvd from run", int'(backup), 1);
      lvd_low = 1'b0;
      wake_count("R4 lvd release wait", 1 + (1 << RW), 1'b1, 1'b0);
      pulse_stop();
      @(negedge clk) lvd_low = 1'b1;
      @(negedge clk);
      chk("R4 backup on lvd from stop", int'(backup), 1);
      lvd_low = 1'b0;
      wake_count("R4 lvd release from stop", 1 + (1 << RW), 1'b1, 1'b0);

      // R9: reset and interrupt accepted on the same edge in stop
      int_wait_sel = 2'd0;
      pulse_stop();
      reset_pin_n = 1'b0;
      repeat (RF - IF_C) @(posedge clk);
      @(negedge clk) ext_int[2] = 1'b1;
      repeat (IF_C + 1) @(posedge clk);
      @(negedge clk);
      chk("R9 reset wins collision", int'(backup), 1);
      chk("R9 oscillator off", int'(osc_en), 0);
      ext_int = '0;
      reset_pin_n = 1'b1;
      wake_count("R9 fixed wait after collision", RST_WAKE, 1'b1, 1'b0);

      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule